// File: doc/BRIEF.md
# Prioritised Interrupt Status and Mask Unit

This unit gathers thirteen level-type interrupt lines from peripherals into one 32-bit pending register. Each line has a fixed bit position in that register. A 32-bit enable register selects which pending bits may reach the processor. The lines fall into three priority groups, and the unit drives a 3-bit processor interrupt level: the highest group level among enabled pending sources, or zero when there are none.

Software reads and writes both registers through a word-wide register port that has a write strobe and a combinational read. A write to the pending register replaces its whole contents. A source line that changes in the same cycle as that write overrides the written value for its own bit. The register port and the interrupt output are plain control signals, with no handshake.

Top module: `irq_prio_unit`

## Requirements
- R1: After reset, both the pending register and the enable register read as zero and `irq_level` is 0.
- R2: A source line that goes from low to high, sampled at a clock edge, sets its pending bit at that edge. The pending bit position for each source index 0..12 is, in order: 7, 3, 2, 9, 10, 12, 5, 17, 28, 27, 26, 23, 21.
- R3: A source line that goes from high to low, sampled at a clock edge, clears its pending bit at that edge. A line that holds its level leaves its bit as it was.
- R4: A register-port write to offset 0x7000 replaces the full 32-bit pending register at the clock edge. Every bit whose source did not change in that cycle takes the written value.
- R5: When a source changes in the same cycle as a pending-register write, the bit for that source follows the source level and ignores the written value.
- R6: A write to offset 0x7800 loads the enable register, which reads back unchanged. A write to any other offset changes neither register.
- R7: A read of any offset other than 0x7000 or 0x7800 returns zero.
- R8: Sources 0 to 6 belong to level 3, source 7 to level 5, and sources 8 to 12 to level 6. `irq_level` is the highest level among sources whose pending bit and enable bit are both set, and 0 if there are none.
- R9: Pending bits that have no source behind them never affect `irq_level`, whatever the enable register holds.
- R10: `irq_level` follows the registers combinationally. It shows the effect of a source event or a register write right after the clock edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 13 | Level interrupt lines, indexed as in R2 |
| reg_addr | input | 16 | Register port byte offset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq_level | output | 3 | Processor interrupt level (0, 3, 5 or 6) |

## Verification
Every result is due at the first clock edge after its stimulus. A source change or a register write driven before an edge shows in the pending register, the enable register and `irq_level` right after that edge. A read is valid in the same cycle its offset is presented. The bench therefore drives on the falling edge, lets exactly one rising edge pass, and samples on the next falling edge. It presents read offsets a short delay before it samples. Two sweeps cover the sources: all 8192 source patterns with every source enabled, and all 8192 enable patterns with every source pending.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int NUM_SRC = 13;
  localparam int REG_W   = 32;

  // fixed pending-bit position of each source index
  function automatic int src_pos(input int k);
    case (k)
      0:  return 7;
      1:  return 3;
      2:  return 2;
      3:  return 9;
      4:  return 10;
      5:  return 12;
      6:  return 5;
      7:  return 17;
      8:  return 28;
      9:  return 27;
      10: return 26;
      11: return 23;
      default: return 21;
    endcase
  endfunction

  // processor level requested by each source index
  function automatic logic [2:0] src_lvl(input int k);
    if (k < 7)       return 3'd3;
    else if (k == 7) return 3'd5;
    else             return 3'd6;
  endfunction

  // all pending bits that have a source of the given level
  function automatic logic [REG_W-1:0] group_bits(input logic [2:0] lvl);
    logic [REG_W-1:0] m;
    m = '0;
    for (int k = 0; k < NUM_SRC; k++)
      if (src_lvl(k) == lvl) m[src_pos(k)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_prio_pkg::*;
#(
  parameter int N_SRC = NUM_SRC,
  parameter int DW    = REG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  input  logic             host_wr,
  input  logic [DW-1:0]    host_wdata,
  output logic [DW-1:0]    status_o
);
  logic [N_SRC-1:0] src_q;
  logic [DW-1:0]    status_q, status_d;

  always_comb begin
    status_d = host_wr ? host_wdata : status_q;
    for (int k = 0; k < N_SRC; k++)
      if (src_i[k] != src_q[k]) status_d[src_pos(k)] = src_i[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q    <= '0;
      status_q <= '0;
    end else begin
      src_q    <= src_i;
      status_q <= status_d;
    end
  end

  assign status_o = status_q;
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] mask_o
);
  logic [DW-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '0;
    else if (host_wr) mask_q <= host_wdata;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/irq_level_enc.sv
module irq_level_enc
  import irq_prio_pkg::*;
#(
  parameter int N_SRC = NUM_SRC,
  parameter int DW    = REG_W
) (
  input  logic [DW-1:0] status_i,
  input  logic [DW-1:0] mask_i,
  output logic [2:0]    level_o
);
  logic [DW-1:0]    pend;
  logic [N_SRC-1:0] hit;
  logic             any3, any5, any6;

  assign pend = status_i & mask_i;

  for (genvar k = 0; k < N_SRC; k++) begin : g_hit
    assign hit[k] = pend[src_pos(k)];
  end

  always_comb begin
    any3 = 1'b0;
    any5 = 1'b0;
    any6 = 1'b0;
    for (int k = 0; k < N_SRC; k++) begin
      if (hit[k] && src_lvl(k) == 3'd3) any3 = 1'b1;
      if (hit[k] && src_lvl(k) == 3'd5) any5 = 1'b1;
      if (hit[k] && src_lvl(k) == 3'd6) any6 = 1'b1;
    end
    if (any6)      level_o = 3'd6;
    else if (any5) level_o = 3'd5;
    else if (any3) level_o = 3'd3;
    else           level_o = 3'd0;
  end
endmodule

// File: rtl/irq_prio_unit.sv
module irq_prio_unit
  import irq_prio_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter logic [15:0] STATUS_OFF = 16'h7000,
  parameter logic [15:0] MASK_OFF   = 16'h7800
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  output logic [2:0]         irq_level
);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STATUS_OFF);
  localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_OFF);

  logic             sel_stat, sel_mask;
  logic [REG_W-1:0] status_q, mask_q;

  assign sel_stat = (reg_addr == STAT_A);
  assign sel_mask = (reg_addr == MASK_A);

  irq_status_reg #(.N_SRC(NUM_SRC), .DW(REG_W)) u_status (
    .clk(clk), .rst_n(rst_n), .src_i(src_i),
    .host_wr(reg_wr && sel_stat), .host_wdata(reg_wdata),
    .status_o(status_q)
  );

  irq_mask_reg #(.DW(REG_W)) u_mask (
    .clk(clk), .rst_n(rst_n),
    .host_wr(reg_wr && sel_mask), .host_wdata(reg_wdata),
    .mask_o(mask_q)
  );

  irq_level_enc #(.N_SRC(NUM_SRC), .DW(REG_W)) u_enc (
    .status_i(status_q), .mask_i(mask_q), .level_o(irq_level)
  );

  always_comb begin
    if (sel_stat)      reg_rdata = status_q;
    else if (sel_mask) reg_rdata = mask_q;
    else               reg_rdata = '0;
  end
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk
  import irq_prio_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] MASK_OFF = 16'h7800
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_i,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic               reg_wr,
  input logic [REG_W-1:0]   reg_wdata,
  input logic [REG_W-1:0]   status_q,
  input logic [REG_W-1:0]   mask_q,
  input logic [2:0]         irq_level
);
  localparam logic [REG_W-1:0] SRC_BITS = group_bits(3'd3) | group_bits(3'd5) | group_bits(3'd6);

  // R2: a rising floppy line (index 0) sets pending bit 7
  a_r2_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_i[0]) |=> status_q[7]);

  // R3: a falling audio line (index 11) clears pending bit 23
  a_r3_fall_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(src_i[11]) |=> !status_q[23]);

  // R6: an enable write is stored as written
  a_r6_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(MASK_OFF)) |=> mask_q == $past(reg_wdata));

  // R8: level 6 only with an enabled pending level-6 source
  a_r8_top_group: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level == 3'd6) |-> ((status_q & mask_q & group_bits(3'd6)) != '0));

  // R9: no enabled pending source means level 0
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & mask_q & SRC_BITS) == '0) |-> irq_level == 3'd0);
endmodule

bind irq_prio_unit irq_prio_chk #(.ADDR_W(ADDR_W), .MASK_OFF(MASK_OFF)) chk_i (
  .clk(clk), .rst_n(rst_n), .src_i(src_i), .reg_addr(reg_addr),
  .reg_wr(reg_wr), .reg_wdata(reg_wdata), .status_q(status_q),
  .mask_q(mask_q), .irq_level(irq_level)
);

// File: tb/irq_prio_unit_tb_top.sv
`timescale 1ns/1ps
module irq_prio_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] src_i = '0;
  logic [15:0] reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [2:0]  irq_level;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_prio_unit dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_level(irq_level)
  );

  localparam logic [15:0] A_STAT = 16'h7000;
  localparam logic [15:0] A_MASK = 16'h7800;

  function automatic int bpos(input int k);
    int t[13] = '{7, 3, 2, 9, 10, 12, 5, 17, 28, 27, 26, 23, 21};
    return t[k];
  endfunction

  function automatic int blvl(input int k);
    return (k < 7) ? 3 : ((k == 7) ? 5 : 6);
  endfunction

  function automatic logic [31:0] spread(input logic [12:0] p);
    logic [31:0] r = '0;
    for (int k = 0; k < 13; k++) if (p[k]) r[bpos(k)] = 1'b1;
    return r;
  endfunction

  function automatic int want_lvl(input logic [12:0] p);
    int l = 0;
    for (int k = 0; k < 13; k++) if (p[k] && blvl(k) > l) l = blvl(k);
    return l;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    reg_addr = a;
    reg_wdata = d;
    reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  initial begin
    #1500000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=finished");
    if (!done) begin
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] sb;
    sb = spread(13'h1fff);
    @(negedge clk);
    tick();
    rst_n = 1'b1;
    // R1 reset state
    rd(A_STAT, d); chk("R1 status", d, 32'h0);
    rd(A_MASK, d); chk("R1 mask", d, 32'h0);
    chk("R1 level", {29'd0, irq_level}, 32'd0);
    // R7 unmapped reads
    rd(16'h7004, d); chk("R7 unmapped", d, 32'h0);
    rd(16'h0000, d); chk("R7 unmapped", d, 32'h0);
    // R6 enable write and read back
    wr(A_MASK, 32'hffff_ffff);
    rd(A_MASK, d); chk("R6 mask rb", d, 32'hffff_ffff);
    // R2 R3 R8 R10 sweep of all source patterns
    for (int p = 0; p < 8192; p++) begin
      src_i = 13'(p);
      tick();
      rd(A_STAT, d); chk("R2 R3 status", d, spread(13'(p)));
      chk("R8 R10 level", {29'd0, irq_level}, 32'(want_lvl(13'(p))));
    end
    src_i = '0;
    tick();
    // R4 full replace with no source activity
    wr(A_STAT, 32'hffff_ffff);
    rd(A_STAT, d); chk("R4 replace", d, 32'hffff_ffff);
    chk("R8 level", {29'd0, irq_level}, 32'd6);
    // R9 sourceless bits
    wr(A_STAT, ~sb);
    rd(A_STAT, d); chk("R4 replace", d, ~sb);
    chk("R9 level", {29'd0, irq_level}, 32'd0);
    // R5 rising event beats written zero
    src_i[5] = 1'b1;
    wr(A_STAT, 32'h0);
    rd(A_STAT, d); chk("R5 rise wins", d, 32'h0000_1000);
    chk("R8 level", {29'd0, irq_level}, 32'd3);
    // R5 falling event beats written one
    src_i[5] = 1'b0;
    wr(A_STAT, 32'hffff_ffff);
    rd(A_STAT, d); chk("R5 fall wins", d, 32'hffff_efff);
    // R3 held line leaves written value alone
    tick();
    rd(A_STAT, d); chk("R3 hold", d, 32'hffff_efff);
    // R6 write elsewhere ignored
    wr(16'h7004, 32'h1234_5678);
    rd(A_STAT, d); chk("R6 ignored status", d, 32'hffff_efff);
    rd(A_MASK, d); chk("R6 ignored mask", d, 32'hffff_ffff);
    // enable sweep with every source pending
    wr(A_STAT, 32'h0);
    src_i = 13'h1fff;
    tick();
    rd(A_STAT, d); chk("R2 all", d, sb);
    for (int m = 0; m < 8192; m++) begin
      wr(A_MASK, spread(13'(m)) | ~sb);
      chk("R8 R9 masked level", {29'd0, irq_level}, 32'(want_lvl(13'(m))));
      rd(A_MASK, d); chk("R6 mask rb", d, spread(13'(m)) | ~sb);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule